// File: doc/BRIEF.md
# SDRAM Data-Lane Pipeline with Latency-Aligned Read Capture

This block is the data half of an SDRAM controller. It sits between the command sequencer and the 16-bit bidirectional DQ bus. On every cycle the sequencer issues a column command, it tells the block whether that command is a read or a write. The block then keeps a beat counter for the programmed burst length. A new column command cuts the running burst short, so bursts issued back to back stream without gaps.

For writes the block drives the data, the output enable and the per-byte mask pins in the same bus cycle as the command beat. For reads it carries a valid token down a short shift register tapped by the programmed CAS latency. It captures the DQ word at the right edge and returns it with a valid flag. The byte-mask pins act with a two-clock delay on reads, so the block lines up its own copy of the mask with the captured word. A masked byte comes back as zero and is flagged as invalid.

Top module: `sdr_dq_path`

## Requirements
- R1: With `cas_lat` set to L (1, 2 or 3), a read command sampled at edge k presents burst beat i on `rd_data` with `rd_valid` high from edge k+1+L+i. The word is the `dq_in` value sampled at that same edge.
- R2: `bl_sel` selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4 and 3 gives 8. An uninterrupted read or write produces exactly that many beats.
- R3: A column command sampled while a burst is running ends that burst. The new burst's first beat follows the old burst's last beat with no idle cycle.
- R4: A write command sampled at edge k raises `dq_oe` from edge k for each write beat. `dq_out` carries the `wr_data` value sampled at the edge of that beat. `dq_out` is zero on every cycle that is not a write beat.
- R5: `dqm` equals `mask_req` registered once, on every cycle. Bit 0 covers bits 7:0 and bit 1 covers bits 15:8, so a write beat and its mask reach the pins together (mask latency 0).
- R6: If `mask_req` bit b is sampled high at edge m, a word captured at edge m+3 returns byte b as zero with `rd_byte_vld` bit b low. Unmasked bytes of a captured word return the bus value with their `rd_byte_vld` bit high.
- R7: On cycles with no captured word, `rd_valid` is low and both `rd_data` and `rd_byte_vld` are zero.
- R8: `dq_oe` is high only on write beats. It is low in the cycle before every read capture edge.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Column command issued this cycle |
| cmd_wr | input | 1 | 1 = write, 0 = read (with cmd_vld) |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| bl_sel | input | 2 | Burst length code (see R2) |
| wr_data | input | 16 | Write word for the current beat |
| mask_req | input | 2 | Per-byte mask request |
| dq_in | input | 16 | Raw DQ bus input |
| dq_oe | output | 1 | DQ output enable |
| dq_out | output | 16 | DQ output data |
| dqm | output | 2 | Byte mask pins (bit 0 low byte) |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | Captured word valid |
| rd_byte_vld | output | 2 | Per-byte validity of rd_data |

## Verification
The bench runs every CAS latency and every burst length. It also drives reads interrupted after one or three beats, single-beat reads on consecutive cycles, and a write cut short by a read. A tap one stage off would shift every captured word by one cycle and pick the wrong bus value. A counter that does not reload on a new command would leave gaps or extra beats in streamed bursts. A read mask delayed by the wrong depth would zero the byte of a neighbouring word. An output enable that lingers after a write would still be high when the first read word lands.

// File: rtl/sdr_dq_path.sv
module sdr_dq_path #(
  parameter int DW      = 16,
  parameter int LAT_MAX = 3,
  parameter int BL_MAX  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  logic          cmd_wr,
  input  logic [1:0]    cas_lat,
  input  logic [1:0]    bl_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    mask_req,
  input  logic [DW-1:0] dq_in,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic [1:0]    dqm,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [1:0]    rd_byte_vld
);
  localparam int NB    = DW / 8;
  localparam int CNT_W = $clog2(BL_MAX);

  logic [CNT_W-1:0] cnt;
  logic             wr_mode;
  logic             rd_iss;
  logic [LAT_MAX-1:0] tok;
  logic [1:0]       msk_d1, msk_d2;
  logic [3:0]       bl_words;
  logic [CNT_W-1:0] bl_m1;
  logic [1:0]       lat_idx;
  logic             beat_now, beat_wr, tap;
  logic [DW-1:0]    cap_word;

  assign bl_words = 4'd1 << bl_sel;
  assign bl_m1    = CNT_W'(bl_words - 4'd1);
  assign beat_now = cmd_vld | (cnt != '0);
  assign beat_wr  = cmd_vld ? cmd_wr : wr_mode;
  assign lat_idx  = (cas_lat == 2'd0) ? 2'd0 : cas_lat - 2'd1;
  assign tap      = tok[lat_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      wr_mode <= 1'b0;
    end else if (cmd_vld) begin
      cnt     <= bl_m1;
      wr_mode <= cmd_wr;
    end else if (cnt != '0) begin
      cnt     <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
      dqm    <= '0;
      rd_iss <= 1'b0;
      tok    <= '0;
      msk_d1 <= '0;
      msk_d2 <= '0;
    end else begin
      dq_oe  <= beat_now & beat_wr;
      dq_out <= (beat_now & beat_wr) ? wr_data : '0;
      dqm    <= mask_req;
      rd_iss <= beat_now & ~beat_wr;
      tok    <= {tok[LAT_MAX-2:0], rd_iss};
      msk_d1 <= dqm;
      msk_d2 <= msk_d1;
    end

  always_comb
    for (int b = 0; b < NB; b++)
      cap_word[b*8 +: 8] = (tap && !msk_d2[b]) ? dq_in[b*8 +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_byte_vld <= '0;
    end else begin
      rd_valid    <= tap;
      rd_data     <= cap_word;
      rd_byte_vld <= tap ? ~msk_d2 : 2'b00;
    end

  a_r1_cl1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_wr && cas_lat == 2'd1) |=> ##2 rd_valid);
  a_r1_cl2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_wr && cas_lat == 2'd2) |=> ##3 rd_valid);
  a_r1_cl3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_wr && cas_lat == 2'd3) |=> ##4 rd_valid);
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_wr && bl_sel == 2'd0) ##1 !cmd_vld |=> !dq_oe);
  a_r4_write_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_wr) |=> dq_oe);
  a_r6_mask_align: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_byte_vld == ~$past(dqm, 3)));
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0 && rd_byte_vld == 2'b00));
  a_r8_bus_turn: assert property (@(posedge clk) disable iff (!rst_n)
    tap |-> !dq_oe);
endmodule

// File: tb/sdr_dq_path_tb.sv
module sdr_dq_path_tb;
  localparam int N = 480;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_vld = 1'b0, cmd_wr = 1'b0;
  logic [1:0] cas_lat = 2'd1, bl_sel = 2'd0, mask_req = 2'd0;
  logic [15:0] wr_data = 16'h0, dq_in = 16'h0;
  logic dq_oe, rd_valid;
  logic [15:0] dq_out, rd_data;
  logic [1:0] dqm, rd_byte_vld;

  always #5 clk = ~clk;

  sdr_dq_path u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cas_lat(cas_lat), .bl_sel(bl_sel), .wr_data(wr_data),
    .mask_req(mask_req), .dq_in(dq_in), .dq_oe(dq_oe), .dq_out(dq_out),
    .dqm(dqm), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_byte_vld(rd_byte_vld));

  typedef struct { int edge_i; logic [15:0] data; logic [1:0] bv; } rd_item_t;
  rd_item_t exp_q[$];

  bit          cv[N], cw[N], eoe[N];
  logic [1:0]  cls[N], bls[N], msk[N];
  logic [15:0] wd[N], edo[N];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [15:0] pat(int e);
    return {8'(e) ^ 8'h5A, 8'(e) + 8'h33};
  endfunction

  task automatic set_phase(int a, int b, int cl, int bs);
    for (int c = a; c <= b; c++) begin cls[c] = 2'(cl); bls[c] = 2'(bs); end
  endtask

  task automatic cmd(int c, bit w);
    cv[c] = 1'b1; cw[c] = w;
  endtask

  task automatic build_expect();
    for (int c = 0; c < N; c++) begin
      int bl, len;
      if (!cv[c]) continue;
      bl = 1 << bls[c];
      len = bl;
      for (int j = 1; j < bl; j++) if (cv[c+j]) begin len = j; break; end
      for (int j = 0; j < len; j++) begin
        if (cw[c]) begin
          eoe[c+j] = 1'b1; edo[c+j] = wd[c+j];
        end else begin
          rd_item_t it;
          int e;
          e = c + 1 + int'(cls[c]) + j;
          it.edge_i = e;
          it.bv = ~msk[e-3];
          it.data = pat(e) & {{8{it.bv[1]}}, {8{it.bv[0]}}};
          exp_q.push_back(it);
        end
      end
    end
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int c);
    rst_n    = (c >= 4);
    cmd_vld  = cv[c]; cmd_wr = cw[c];
    cas_lat  = cls[c]; bl_sel = bls[c];
    mask_req = msk[c]; wr_data = wd[c];
    dq_in    = pat(c);
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      cv[c] = 0; cw[c] = 0; eoe[c] = 0; edo[c] = 16'h0;
      cls[c] = 2'd1; bls[c] = 2'd0;
      wd[c] = 16'hA000 ^ 16'(c * 16'h0111);
      msk[c] = (c < 6) ? 2'b00 : (c % 7 == 3) ? 2'b01 : (c % 11 == 5) ? 2'b10 :
               (c % 13 == 0) ? 2'b11 : 2'b00;
    end
    set_phase(0, 59, 2, 0);    cmd(10, 0); cmd(20, 0);               // R1 CL2
    set_phase(60, 119, 3, 2);  cmd(62, 0); cmd(80, 0);               // R1 CL3, R2 BL4
    set_phase(120, 179, 1, 1); cmd(122, 0); cmd(124, 0); cmd(126, 0); // R3 streaming CL1
    cmd(140, 0); cmd(141, 0);                                        // R3 cut after one beat
    set_phase(180, 259, 2, 3); cmd(182, 1);                          // R4 BL8 write
    cmd(200, 0); cmd(203, 0);                                        // R3 read cut at three
    cmd(230, 1); cmd(233, 1);                                        // R3 write cut by write
    set_phase(260, 339, 3, 2); cmd(262, 1); cmd(264, 0);             // R8 write then read
    cmd(290, 1);
    set_phase(340, 419, 3, 0);
    for (int c = 342; c <= 346; c++) cmd(c, 0);                      // R3 one-beat reads each cycle
    for (int c = 380; c <= 383; c++) cmd(c, 1);
    cmd(400, 0);
    set_phase(420, 479, 1, 3); cmd(422, 0);                          // R1 CL1, R2 BL8
    build_expect();

    drive(0);
    for (int e = 0; e < N - 1; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 2) // R9 reset state
        check(dq_oe == 0 && dq_out == 0 && dqm == 0 && rd_valid == 0 &&
              rd_data == 0 && rd_byte_vld == 0, "R9 reset",
              {dq_oe, rd_valid, dqm, rd_byte_vld, rd_data[7:0], dq_out[7:0]}, 32'h0);
      if (e >= 4) begin
        check(dq_oe == eoe[e], "R4 R8 dq_oe", 32'(dq_oe), 32'(eoe[e]));
        check(dq_out == edo[e], "R4 dq_out", 32'(dq_out), 32'(edo[e]));
        check(dqm == msk[e], "R5 dqm", 32'(dqm), 32'(msk[e]));
        if (rd_valid) begin
          if (exp_q.size() == 0 || exp_q[0].edge_i != e)
            check(1'b0, "R1 R2 R3 unexpected rd_valid", 32'(e),
                  exp_q.size() ? 32'(exp_q[0].edge_i) : 32'hFFFF);
          else begin
            rd_item_t it;
            it = exp_q.pop_front();
            check(rd_data == it.data, "R1 R6 rd_data", 32'(rd_data), 32'(it.data));
            check(rd_byte_vld == it.bv, "R6 rd_byte_vld", 32'(rd_byte_vld), 32'(it.bv));
          end
        end else begin
          if (exp_q.size() != 0 && exp_q[0].edge_i == e) begin
            check(1'b0, "R1 R2 R3 missing read word", 32'(0), 32'(e));
            void'(exp_q.pop_front());
          end
          check(rd_data == 0 && rd_byte_vld == 0, "R7 idle outputs",
                {14'h0, rd_byte_vld, rd_data}, 32'h0);
        end
      end
      drive(e + 1);
    end
    check(exp_q.size() == 0, "R2 all read words delivered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(N * 10 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule